// File: doc/BRIEF.md
# Register-Mapped Data EEPROM Controller

This block lets a CPU use a small non-volatile byte store of 64 locations. The array is not visible in the CPU's address space. The CPU reaches it only through four registers, chosen by a 2-bit select: a control register, a key register that unlocks writes, a data register and an address register. Register writes are strobed. Register reads are combinational on the select.

A read is a single control write that sets the read-start bit. On the next clock edge the addressed byte moves into the data register, and hardware clears the read-start bit.

A write needs three things:
- the key register has just received two fixed key bytes in a row;
- write enable is set in the same control write;
- the write-start bit is set in that control write.

A timer then runs for a parameterised number of cycles. The location is erased (set to 0xFF) as the write starts and programmed with the new byte when the timer ends. Completion raises an interrupt flag that software must clear. A reset that lands during a write abandons the write and raises an error flag that the reset does not clear.

Top module: `eeprom_regctl`

## Requirements
- R1: Select codes are 0 = control, 1 = key, 2 = data, 3 = address. The key register reads as 0x00. The control register reads as {3'b000, done flag (bit 4), error flag (bit 3), write enable (bit 2), write start (bit 1), read start (bit 0)}.
- R2: A control write with bit 0 = 1 sets read start for exactly one cycle. On the following edge the data register takes the byte at the current address.
- R3: Writing 0 to read start or write start does not clear them. Only hardware clears these bits.
- R4: A write start is accepted only when the two register writes just before the control write were 0x55 and then 0xAA to the key register. Otherwise the request is dropped and the array is left unchanged.
- R5: Write enable resets to 0. A write start in a control write whose bit 2 is 0 is dropped.
- R6: After an accepted start, write start reads 1 for exactly WRITE_CYCLES cycles and then clears. The done flag sets in the same cycle, and the location then holds the new byte.
- R7: The done flag and the `irq` output stay 1 until software writes 0 to control bit 4.
- R8: While a write is in progress, writes to the address and data registers are ignored.
- R9: Only an address with bits 7:6 = 00 reaches the array. Any other address leaves the data register unchanged on a read and modifies no location on a write, although the write timer and done flag still run.
- R10: A reset during a write abandons it, sets the error flag, and leaves the location erased at 0xFF. The same reset clears read start, write start, write enable and the done flag.
- R11: Array contents are kept across reset.
- R12: Software can set and clear the error flag through control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back value of the selected register |
| irq | output | 1 | Write-done interrupt (copy of the done flag) |

## Verification
Most wrong internal state shows up in the control register within one cycle.

- A stuck read start stays visible past its single cycle.
- A timer that counts wrong moves the fall of write start and the rise of the done flag off cycle WRITE_CYCLES.
- A key detector that is too permissive shows as write start rising after a bad key sequence.

Array corruption, an erase that is missing, or a program cycle that was not aborted appears only on the next read of the affected location. The bench therefore reads back every location it has touched.

// File: rtl/eerc_pkg.sv
// Package: shared register select codes, control bit positions and key bytes.
package eerc_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_KEY    = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_ADDR   = 2'd3
    } eerc_sel_e;

    localparam int unsigned BIT_RD   = 0;
    localparam int unsigned BIT_WR   = 1;
    localparam int unsigned BIT_WREN = 2;
    localparam int unsigned BIT_ERR  = 3;
    localparam int unsigned BIT_DONE = 4;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/eerc_unlock.sv
// Key sequence detector. It arms after KEY_FIRST and then KEY_SECOND are
// written to the key register on consecutive register writes. Any other
// register write disarms it, including the control write that consumes it.
// Assumes acc_valid is already qualified by reset.
module eerc_unlock
    import eerc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_key,
    input  logic [DATA_W-1:0] acc_data,
    output logic              armed
);
    typedef enum logic [1:0] {U_IDLE, U_HALF, U_ARMED} ustate_e;
    ustate_e state_q;

    // Step the key sequence on every register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
        end else if (acc_valid) begin
            if (acc_key && acc_data == DATA_W'(KEY_FIRST))
                state_q <= U_HALF;
            else if (acc_key && acc_data == DATA_W'(KEY_SECOND) && state_q == U_HALF)
                state_q <= U_ARMED;
            else
                state_q <= U_IDLE;
        end
    end

    assign armed = (state_q == U_ARMED);
endmodule

// File: rtl/eerc_write_timer.sv
// Write-cycle timer. A start pulse makes it busy for CYCLES clock cycles.
// done is high in the last busy cycle. Assumes start only arrives when idle.
module eerc_write_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down while busy, drop busy after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/eerc_byte_array.sv
// Behavioural byte store with one synchronous write port and a combinational
// read port. It has no reset, so its contents survive reset.
module eerc_byte_array #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned DEPTH_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [DEPTH_LOG2-1:0] waddr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DEPTH_LOG2-1:0] raddr,
    output logic [DATA_W-1:0]     rdata
);
    localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
    logic [DATA_W-1:0] cells [DEPTH];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_regctl.sv
// Top level: the register file, control-bit behaviour and sequencing of the
// erase/program cycle. Assumes one register write per strobe cycle and a
// synchronous active-low reset that may arrive during a write.
// The error flag has no reset value, so software defines it at start-up.
module eeprom_regctl
    import eerc_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned DEPTH_LOG2   = 6,
    parameter int unsigned WRITE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    eerc_sel_e sel;
    logic acc, ctrl_wr, key_wr, data_wr, addr_wr;
    logic armed, busy, done, done_eff, wr_req, addr_ok;
    logic rd_q, wr_q, wren_q, err_q, done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, lat_data_q, arr_rdata, arr_wdata;
    logic [DEPTH_LOG2-1:0] lat_addr_q, arr_waddr;
    logic lat_ok_q, arr_we;

    assign sel      = eerc_sel_e'(reg_sel);
    assign acc      = reg_wr && rst_n;
    assign ctrl_wr  = acc && sel == SEL_CTRL;
    assign key_wr   = acc && sel == SEL_KEY;
    assign data_wr  = acc && sel == SEL_DATA && !busy;
    assign addr_wr  = acc && sel == SEL_ADDR && !busy;
    assign addr_ok  = (addr_q[ADDR_W-1:DEPTH_LOG2] == '0);
    assign wr_req   = ctrl_wr && reg_wdata[BIT_WR] && reg_wdata[BIT_WREN] && armed && !busy;
    assign done_eff = done && rst_n;

    eerc_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc), .acc_key(key_wr),
        .acc_data(reg_wdata), .armed(armed)
    );

    eerc_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_req), .busy(busy), .done(done)
    );

    // Erase at the start of an accepted write, program when the timer ends.
    assign arr_we    = (wr_req && addr_ok) || (done_eff && lat_ok_q);
    assign arr_waddr = done_eff ? lat_addr_q : addr_q[DEPTH_LOG2-1:0];
    assign arr_wdata = done_eff ? lat_data_q : ERASED;

    eerc_byte_array #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_array (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(addr_q[DEPTH_LOG2-1:0]), .rdata(arr_rdata)
    );

    // Read start: set by software, held for one cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= ctrl_wr && reg_wdata[BIT_RD];
    end

    // Write start: set on an accepted request, cleared when the timer ends.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_q <= 1'b0;
        else if (wr_req) wr_q <= 1'b1;
        else if (done)   wr_q <= 1'b0;
    end

    // Write enable: plain software bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       wren_q <= 1'b0;
        else if (ctrl_wr) wren_q <= reg_wdata[BIT_WREN];
    end

    // Done flag: set by hardware (which wins), cleared by software or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       done_q <= 1'b0;
        else if (done)    done_q <= 1'b1;
        else if (ctrl_wr) done_q <= reg_wdata[BIT_DONE];
    end

    // Error flag: raised by a reset that hits a running write, otherwise kept.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= err_q | busy;
        else if (ctrl_wr) err_q <= reg_wdata[BIT_ERR];
    end

    // Address register: frozen while a write runs.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_wr) addr_q <= ADDR_W'(reg_wdata);
    end

    // Data register: loaded by a completed read or by software when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (rd_q && addr_ok)  data_q <= arr_rdata;
        else if (data_wr)          data_q <= reg_wdata;
    end

    // Capture the target of an accepted write so later accesses cannot disturb it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr_q <= '0;
            lat_data_q <= '0;
            lat_ok_q   <= 1'b0;
        end else if (wr_req) begin
            lat_addr_q <= addr_q[DEPTH_LOG2-1:0];
            lat_data_q <= data_q;
            lat_ok_q   <= addr_ok;
        end
    end

    // Read-back multiplexer for the selected register.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                reg_rdata[BIT_RD]   = rd_q;
                reg_rdata[BIT_WR]   = wr_q;
                reg_rdata[BIT_WREN] = wren_q;
                reg_rdata[BIT_ERR]  = err_q;
                reg_rdata[BIT_DONE] = done_q;
            end
            SEL_KEY:  reg_rdata = '0;
            SEL_DATA: reg_rdata = data_q;
            SEL_ADDR: reg_rdata = DATA_W'(addr_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = done_q;
endmodule

// File: rtl/eeprom_regctl_checker.sv
// Assertion checker bound to eeprom_regctl. It watches the ports and the
// control state and holds no logic of its own.
module eeprom_regctl_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              rd_q,
    input logic              wr_q,
    input logic              done_q,
    input logic              err_q,
    input logic              busy,
    input logic              armed,
    input logic [ADDR_W-1:0] addr_q
);
    assert_ctrl_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> (reg_rdata[DATA_W-1:5] == '0));

    assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |=> !rd_q);

    assert_key_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_q) && $past(rst_n)) |-> $past(armed));

    assert_enable_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_q) && $past(rst_n)) |->
            $past(reg_wr && reg_sel == 2'd0 && reg_wdata[2] && reg_wdata[1]));

    assert_busy_has_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wr_q);

    assert_done_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_q) && $past(rst_n)) |-> done_q);

    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_sel == 2'd3) |=> $stable(addr_q));

    assert_abort_err_R10: assert property (@(posedge clk)
        (!rst_n && busy) |=> err_q);
endmodule

bind eeprom_regctl eeprom_regctl_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_q(rd_q), .wr_q(wr_q),
    .done_q(done_q), .err_q(err_q), .busy(busy), .armed(armed), .addr_q(addr_q)
);

// File: tb/test_eeprom_regctl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_eeprom_regctl;
    localparam int unsigned WCYC = 16;
    localparam logic [1:0] S_CTRL = 2'd0, S_KEY = 2'd1, S_DATA = 2'd2, S_ADDR = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    eeprom_regctl #(.WRITE_CYCLES(WCYC)) i_eeprom_regctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic start_write(input logic [7:0] a, input logic [7:0] d);
        wreg(S_ADDR, a);
        wreg(S_DATA, d);
        wreg(S_KEY, 8'h55);
        wreg(S_KEY, 8'hAA);
        wreg(S_CTRL, 8'h06);
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 4 * WCYC; i++) begin
            peek(S_CTRL, c);
            if (!c[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic ee_read(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] c;
        wreg(S_ADDR, a);
        wreg(S_CTRL, 8'h01);
        peek(S_CTRL, c);
        chk("R2 read start set", c & 8'h01, 8'h01);
        @(negedge clk);
        peek(S_CTRL, c);
        chk("R2 read start self-clears", c & 8'h01, 8'h00);
        peek(S_DATA, v);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        peek(S_CTRL, v);
        chk("R1 pad bits zero", v & 8'hE0, 8'h00);
        chk("R5 reset clears rd/wr/wren/done", v & 8'hF7, 8'h00);
        chk("R7 irq low after reset", {7'd0, irq}, 8'h00);
        peek(S_KEY, v);
        chk("R1 key register reads zero", v, 8'h00);
        wreg(S_CTRL, 8'h08);
        peek(S_CTRL, v);
        chk("R12 error flag set by software", v, 8'h08);
        wreg(S_CTRL, 8'h00);
        peek(S_CTRL, v);
        chk("R12 error flag cleared by software", v, 8'h00);
        wreg(S_CTRL, 8'h04);
        pulse_reset();
        peek(S_CTRL, v);
        chk("R5 reset clears write enable", v & 8'h04, 8'h00);
    endtask

    task automatic t_basic_write();
        logic [7:0] v;
        start_write(8'h05, 8'hA5);
        peek(S_CTRL, v);
        chk("R6 write start accepted", v & 8'h12, 8'h02);
        repeat (WCYC - 1) @(negedge clk);
        peek(S_CTRL, v);
        chk("R6 write still running at last cycle", v & 8'h12, 8'h02);
        @(negedge clk);
        peek(S_CTRL, v);
        chk("R6 write ends and done flag sets", v & 8'h12, 8'h10);
        repeat (3) @(negedge clk);
        chk("R7 irq held", {7'd0, irq}, 8'h01);
        wreg(S_CTRL, 8'h00);
        chk("R7 irq cleared by software", {7'd0, irq}, 8'h00);
        ee_read(8'h05, v);
        chk("R6 programmed byte reads back", v, 8'hA5);
    endtask

    task automatic t_busy_ignores();
        logic [7:0] v;
        start_write(8'h0A, 8'h3C);
        wreg(S_CTRL, 8'h04);
        peek(S_CTRL, v);
        chk("R3 write start not cleared by software", v & 8'h02, 8'h02);
        wreg(S_ADDR, 8'h10);
        wreg(S_DATA, 8'h00);
        peek(S_ADDR, v);
        chk("R8 address frozen while busy", v, 8'h0A);
        peek(S_DATA, v);
        chk("R8 data frozen while busy", v, 8'h3C);
        wait_idle();
        ee_read(8'h0A, v);
        chk("R8 write used captured byte", v, 8'h3C);
        ee_read(8'h10, v);
        chk("R8 ignored address untouched", v === 8'h3C ? 8'h00 : 8'h01, 8'h01);
    endtask

    task automatic t_key_rules();
        logic [7:0] v;
        start_write(8'h07, 8'h33);
        wait_idle();
        wreg(S_ADDR, 8'h07); wreg(S_DATA, 8'h11); wreg(S_CTRL, 8'h06);
        peek(S_CTRL, v);
        chk("R4 no key sequence drops start", v & 8'h02, 8'h00);
        wreg(S_KEY, 8'h55); wreg(S_DATA, 8'h11); wreg(S_KEY, 8'hAA); wreg(S_CTRL, 8'h06);
        peek(S_CTRL, v);
        chk("R4 interrupted key sequence drops start", v & 8'h02, 8'h00);
        wreg(S_KEY, 8'hAA); wreg(S_KEY, 8'h55); wreg(S_CTRL, 8'h06);
        peek(S_CTRL, v);
        chk("R4 reversed key order drops start", v & 8'h02, 8'h00);
        wreg(S_KEY, 8'h55); wreg(S_KEY, 8'hAA); wreg(S_CTRL, 8'h02);
        peek(S_CTRL, v);
        chk("R5 start without enable dropped", v & 8'h02, 8'h00);
        repeat (WCYC + 2) @(negedge clk);
        ee_read(8'h07, v);
        chk("R4 dropped requests leave byte", v, 8'h33);
    endtask

    task automatic t_range();
        logic [7:0] v;
        start_write(8'h09, 8'h5A);
        wait_idle();
        wreg(S_CTRL, 8'h00);
        start_write(8'h49, 8'hC3);
        peek(S_CTRL, v);
        chk("R9 out-of-range write still timed", v & 8'h02, 8'h02);
        wait_idle();
        peek(S_CTRL, v);
        chk("R9 out-of-range write raises done", v & 8'h10, 8'h10);
        ee_read(8'h09, v);
        chk("R9 aliased location untouched", v, 8'h5A);
        wreg(S_DATA, 8'h77);
        wreg(S_ADDR, 8'h89);
        wreg(S_CTRL, 8'h01);
        @(negedge clk);
        peek(S_DATA, v);
        chk("R9 out-of-range read leaves data", v, 8'h77);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        start_write(8'h12, 8'h44);
        wait_idle();
        start_write(8'h12, 8'h99);
        repeat (4) @(negedge clk);
        pulse_reset();
        peek(S_CTRL, v);
        chk("R10 abort sets error and clears rest", v, 8'h08);
        repeat (WCYC + 2) @(negedge clk);
        peek(S_CTRL, v);
        chk("R10 error survives and no late done", v, 8'h08);
        ee_read(8'h12, v);
        chk("R10 aborted location left erased", v, 8'hFF);
        ee_read(8'h05, v);
        chk("R11 contents kept across reset", v, 8'hA5);
        start_write(8'h12, 8'h66);
        wait_idle();
        ee_read(8'h12, v);
        chk("R6 write after abort succeeds", v, 8'h66);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic_write();
        t_busy_ignores();
        t_key_rules();
        t_range();
        t_abort();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule